// File: doc/BRIEF.md
# Domain Access Checker

This block is the domain stage of a memory management unit's permission path. It holds a 32-bit domain control word made of sixteen 2-bit fields, one per domain. When a translation presents a descriptor's 4-bit domain number together with a valid strobe, the block reads that domain's field and gives one of three verdicts:

- the access raises a domain fault;
- the access is handed on to the descriptor permission check;
- the permission check is skipped and the access is allowed.

The verdict is combinational from the request inputs and the stored word. The stored word is loaded through a single-cycle write port. A load becomes visible to requests in the cycle after it is written. The word clears to zero on reset, so every domain refuses access until software sets it up.

Top module: `domain_access_checker`

## Requirements
- R1: After reset the control word is zero, so a valid request for any of the sixteen domains raises domainFault.
- R2: The field for domain n sits at control-word bits 2n+1:2n, and only that field decides the verdict for domain n.
- R3: Field value 2'b00 (deny) with reqValid high gives domainFault=1, permCheck=0, permBypass=0.
- R4: Field value 2'b01 (client) with reqValid high gives permCheck=1, domainFault=0, permBypass=0.
- R5: Field value 2'b11 (manager) with reqValid high gives permBypass=1, domainFault=0, permCheck=0.
- R6: Field value 2'b10 (reserved) is handled as deny: domainFault=1, permCheck=0, permBypass=0.
- R7: While reqValid is low, domainFault, permCheck and permBypass are all 0, whatever the domain number and the word hold.
- R8: While reqValid is high, exactly one of domainFault, permCheck and permBypass is 1.
- R9: With wrEn high at a rising clock edge, wrData becomes the control word from the next cycle on. A request in the same cycle as the write is judged against the old word.
- R10: While wrEn is low the control word keeps its value, whatever wrData carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset, clears the control word |
| wrEn | input | 1 | Load strobe for the control word |
| wrData | input | 32 | New control word value |
| reqValid | input | 1 | A domain check is requested this cycle |
| reqDomain | input | 4 | Domain number from the descriptor |
| domainFault | output | 1 | Access refused by the domain setting |
| permCheck | output | 1 | Descriptor permission bits must be checked |
| permBypass | output | 1 | Permission check is skipped for this access |

## Verification
A load through the write port and a domain check can fall in the same cycle. The outcome then depends on whether the check sees the old word or the new one. The bench provokes this by holding a request steady while it writes a word whose field for that domain has a different mode. It expects the verdict of the old word before the edge, and the verdict of the new word after the edge. Around this, every domain is swept under word patterns that rotate all four modes through all sixteen fields.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int FIELD_W = 2;

  typedef enum logic [FIELD_W-1:0] {
    DOM_DENY    = 2'b00,
    DOM_CLIENT  = 2'b01,
    DOM_RSVD    = 2'b10,
    DOM_MANAGER = 2'b11
  } domMode_e;

  typedef struct packed {
    logic loadWord;
  } dpStrobe_t;
endpackage

// File: rtl/dac_datapath.sv
module dac_datapath
  import dac_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  localparam int WORD_W = NUM_DOMAINS * FIELD_W,
  localparam int DOM_W = $clog2(NUM_DOMAINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [DOM_W-1:0]  reqDomain,
  output domMode_e          domMode
);
  logic [WORD_W-1:0] wordQ;
  logic [FIELD_W-1:0] fieldArr [NUM_DOMAINS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobe.loadWord) begin
      wordQ <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_field
    assign fieldArr[g] = wordQ[g*FIELD_W +: FIELD_W];
  end

  assign domMode = domMode_e'(fieldArr[reqDomain]);
endmodule

// File: rtl/dac_control.sv
module dac_control
  import dac_pkg::*;
(
  input  logic      wrEn,
  input  logic      reqValid,
  input  domMode_e  domMode,
  output dpStrobe_t strobe,
  output logic      domainFault,
  output logic      permCheck,
  output logic      permBypass
);
  always_comb begin
    strobe.loadWord = wrEn;
    domainFault = 1'b0;
    permCheck   = 1'b0;
    permBypass  = 1'b0;
    if (reqValid) begin
      unique case (domMode)
        DOM_CLIENT:  permCheck   = 1'b1;
        DOM_MANAGER: permBypass  = 1'b1;
        default:     domainFault = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/domain_access_checker.sv
module domain_access_checker
  import dac_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  localparam int WORD_W = NUM_DOMAINS * FIELD_W,
  localparam int DOM_W = $clog2(NUM_DOMAINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              reqValid,
  input  logic [DOM_W-1:0]  reqDomain,
  output logic              domainFault,
  output logic              permCheck,
  output logic              permBypass
);
  dpStrobe_t strobe;
  domMode_e  domMode;

  dac_datapath #(.NUM_DOMAINS(NUM_DOMAINS)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .reqDomain (reqDomain),
    .domMode   (domMode)
  );

  dac_control i_control (
    .wrEn        (wrEn),
    .reqValid    (reqValid),
    .domMode     (domMode),
    .strobe      (strobe),
    .domainFault (domainFault),
    .permCheck   (permCheck),
    .permBypass  (permBypass)
  );
endmodule

// File: rtl/dac_checker.sv
module dac_checker #(
  parameter int WORD_W = 32,
  parameter int DOM_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [WORD_W-1:0] wrData,
  input logic              reqValid,
  input logic [DOM_W-1:0]  reqDomain,
  input logic [WORD_W-1:0] wordQ,
  input logic              domainFault,
  input logic              permCheck,
  input logic              permBypass
);
  logic [1:0] selField;
  assign selField = wordQ[reqDomain*2 +: 2];

  p_exactly_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({domainFault, permCheck, permBypass}) == 1);

  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(domainFault || permCheck || permBypass));

  p_deny_fault_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && selField == 2'b00) |-> domainFault);

  p_client_check_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && selField == 2'b01) |-> permCheck);

  p_manager_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && selField == 2'b11) |-> permBypass);

  p_reserved_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && selField == 2'b10) |-> domainFault);

  p_load_next_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> wordQ == $past(wrData));

  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(wordQ));
endmodule

bind domain_access_checker dac_checker #(.WORD_W(WORD_W), .DOM_W(DOM_W)) i_dac_checker (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .reqValid    (reqValid),
  .reqDomain   (reqDomain),
  .wordQ       (i_datapath.wordQ),
  .domainFault (domainFault),
  .permCheck   (permCheck),
  .permBypass  (permBypass)
);

// File: tb/test_domain_access_checker.sv
module test_domain_access_checker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqDomain = '0;
  logic        domainFault, permCheck, permBypass;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  domain_access_checker i_domain_access_checker (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .reqValid(reqValid), .reqDomain(reqDomain),
    .domainFault(domainFault), .permCheck(permCheck), .permBypass(permBypass)
  );

  function automatic logic [2:0] expectFor(input logic [31:0] word, input int d);
    logic [1:0] m;
    m = 2'((word >> (2*d)) & 32'h3);
    case (m)
      2'b01:   return 3'b010;
      2'b11:   return 3'b001;
      default: return 3'b100;
    endcase
  endfunction

  function automatic string tagFor(input logic [31:0] word, input int d);
    logic [1:0] m;
    m = 2'((word >> (2*d)) & 32'h3);
    case (m)
      2'b00:   return "R2 R3";
      2'b01:   return "R2 R4";
      2'b10:   return "R2 R6";
      default: return "R2 R5";
    endcase
  endfunction

  task automatic compare(input logic [2:0] exp, input string tag, input int d);
    logic [2:0] act;
    act = {domainFault, permCheck, permBypass};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s domain %0d: got {fault,check,bypass}=%b expected %b", tag, d, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] word);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = word;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sweep(input logic [31:0] word, input string extra);
    for (int d = 0; d < 16; d++) begin
      reqValid = 1'b1;
      reqDomain = 4'(d);
      #1;
      compare(expectFor(word, d), {extra, tagFor(word, d), " R8"}, d);
      #1;
    end
    reqValid = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w;
    logic [31:0] oldW;
    logic [31:0] newW;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset word is zero, every domain faults
    sweep(32'h0, "R1 ");

    // rotated patterns cover all modes in all fields
    for (int k = 0; k < 4; k++) begin
      w = '0;
      for (int n = 0; n < 16; n++) w |= 32'((n + k) % 4) << (2*n);
      doWrite(w);
      sweep(w, "R9 ");
    end
    // single-field patterns: only domain n is manager (R2 isolation)
    for (int n = 0; n < 16; n += 5) begin
      w = 32'h3 << (2*n);
      doWrite(w);
      sweep(w, "");
    end
    w = 32'hFFFF_FFFF; doWrite(w); sweep(w, "");
    w = 32'hAAAA_AAAA; doWrite(w); sweep(w, "");
    w = 32'h5555_5555; doWrite(w); sweep(w, "");
    w = 32'h1B6C_93E4; doWrite(w); sweep(w, "");

    // R7: idle request, outputs low for every domain
    @(negedge clk);
    for (int d = 0; d < 16; d++) begin
      reqValid = 1'b0;
      reqDomain = 4'(d);
      #1;
      compare(3'b000, "R7", d);
    end

    // R10: wrData churns while wrEn is low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wrData = 32'h0F0F_0000 ^ 32'(i * 32'h1357_9BDF);
    end
    @(negedge clk);
    sweep(w, "R10 ");

    // R9: write and request in the same cycle
    oldW = 32'h0000_0010;
    newW = 32'h0000_0030;
    doWrite(oldW);
    @(negedge clk);
    reqValid = 1'b1;
    reqDomain = 4'd2;
    wrEn = 1'b1;
    wrData = newW;
    #1;
    compare(3'b010, "R9 same-cycle old word", 2);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    compare(3'b001, "R9 new word after edge", 2);
    reqValid = 1'b0;

    // R1 again: reset clears a configured word
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    sweep(32'h0, "R1 ");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule